// File: doc/BRIEF.md
# Parallel DAC Bus Write Sequencer

This block sits on the host side of an eight-channel, double-buffered voltage-output converter with a parallel bus. It accepts commands through a valid/ready handshake. A command either writes a signed sample to one channel or asks for a global update. For a write, it converts the sample from two's complement to offset binary and drives the address and data lines. It then pulses chip-select and write low together, holding the pulse long enough to meet the converter's minimum pulse width and data setup time.

A global update drives the shared load line low. The falling edge of load comes a programmable gap after chip-select returns high, so the converter's deglitch stage sees settled input latches. With auto-load enabled, every write is followed by its own load pulse. With auto-load disabled, several channel writes can be batched and then applied together by a single update command. Every delay is given in nanoseconds and converted to clock cycles, rounding up, with a minimum of one cycle.

Top module: `dac_bus_sequencer`

## Requirements
- R1: During and right after reset, `bus_cs_n`, `bus_wr_n` and `bus_ld_n` are high, `bus_addr` and `bus_data` are zero, `cmd_ready` is high and `busy` is low.
- R2: A write is accepted on a clock edge where `cmd_valid`, `cmd_ready` are high and `cmd_update` is 0. From the next cycle on, `bus_addr` equals `cmd_chan` and `bus_data` equals `cmd_sample` plus 8192 modulo 2^14 (the top bit inverted).
- R3: `bus_cs_n` and `bus_wr_n` fall SETUP cycles after the address and data change (ceil(15 ns / period), which is 1 at the default).
- R4: `bus_cs_n` and `bus_wr_n` are low together for exactly PULSE cycles: the larger of the strobe width and data setup, each 50 ns rounded up, which is 3 at default.
- R5: `bus_addr` and `bus_data` change only in the cycle after an accepted write. They stay stable while the strobe is low and after it rises.
- R6: When auto-load is in effect for a write, `bus_ld_n` falls GAP cycles after `bus_cs_n` rises (3 at default) and stays low for LOAD cycles (3 at default). After that the block returns to idle.
- R7: When auto-load is not in effect, a write produces no load pulse. The block returns to idle HOLD cycles (1 at default) after the strobe rises.
- R8: An update command (`cmd_update` = 1) produces no strobe. It produces one load pulse that falls GAP cycles after acceptance and lasts LOAD cycles, leaving the bus address and data unchanged. This lets earlier batched writes take effect together.
- R9: `cmd_ready` is low and `busy` is high in every cycle of a bus or load phase. A command presented then is not taken, and it leaves address, data and outputs untouched.
- R10: `bus_ld_n` and `bus_wr_n` are never low in the same cycle.
- R11: The `auto_load` level is captured when a write is accepted. Changing it during the sequence does not alter that write's load behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_load | input | 1 | 1: follow each write with a load pulse |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_update | input | 1 | 0: channel write, 1: global update |
| cmd_chan | input | 3 | Target channel for a write |
| cmd_sample | input | 14 | Signed two's-complement sample |
| busy | output | 1 | A bus or load phase is running |
| bus_cs_n | output | 1 | Converter chip-select, active low |
| bus_wr_n | output | 1 | Converter write strobe, active low |
| bus_addr | output | 3 | Converter channel address |
| bus_data | output | 14 | Offset-binary data word |
| bus_ld_n | output | 1 | Converter load, active low |

## Verification
After the accept edge, address and data are valid one cycle later. The strobe falls after SETUP more cycles and rises after PULSE more. Load falls GAP cycles after the strobe rises, or GAP cycles after acceptance for an update. It stays low for LOAD cycles, after which ready returns. The bench model queues one expected output vector per cycle when it sees an acceptance at a rising edge. It compares all outputs on the following falling edge, so every phase boundary is checked in the exact cycle it is due. Directed checks after each sequence confirm the held data, the channel, and the number of load falls.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_GAP,
    ST_LOAD
  } seq_state_t;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dacseq_code_conv.sv
module dacseq_code_conv #(
  parameter int W = 14
) (
  input  logic [W-1:0] twos_in,
  output logic [W-1:0] offs_out
);
  // adding half scale modulo 2^W flips only the sign bit
  assign offs_out = {~twos_in[W-1], twos_in[W-2:0]};
endmodule

// File: rtl/dacseq_phase_timer.sv
module dacseq_phase_timer #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          last
);
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);
endmodule

// File: rtl/dacseq_bus_regs.sv
module dacseq_bus_regs #(
  parameter int AW = 3,
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] data_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (en) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end
endmodule

// File: rtl/dac_bus_sequencer.sv
module dac_bus_sequencer
  import dacseq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int CH_W          = 3,
  parameter int SMP_W         = 14,
  parameter int ADDR_SETUP_NS = 15,
  parameter int STROBE_NS     = 50,
  parameter int DATA_SETUP_NS = 50,
  parameter int HOLD_NS       = 0,
  parameter int LOAD_GAP_NS   = 50,
  parameter int LOAD_NS       = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             auto_load,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_update,
  input  logic [CH_W-1:0]  cmd_chan,
  input  logic [SMP_W-1:0] cmd_sample,
  output logic             busy,
  output logic             bus_cs_n,
  output logic             bus_wr_n,
  output logic [CH_W-1:0]  bus_addr,
  output logic [SMP_W-1:0] bus_data,
  output logic             bus_ld_n
);
  localparam int SETUP_CYC = ns_to_cyc(ADDR_SETUP_NS, CLK_PERIOD_NS);
  localparam int PULSE_CYC = max2(ns_to_cyc(STROBE_NS, CLK_PERIOD_NS),
                                  ns_to_cyc(DATA_SETUP_NS, CLK_PERIOD_NS));
  localparam int HOLD_CYC  = ns_to_cyc(HOLD_NS, CLK_PERIOD_NS);
  localparam int GAP_CYC   = ns_to_cyc(LOAD_GAP_NS, CLK_PERIOD_NS);
  localparam int LD_CYC    = ns_to_cyc(LOAD_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC   = max2(max2(SETUP_CYC, PULSE_CYC),
                                  max2(max2(HOLD_CYC, GAP_CYC), LD_CYC));
  localparam int TW        = $clog2(MAX_CYC + 1);

  localparam logic [TW-1:0] SETUP_LV = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] PULSE_LV = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] HOLD_LV  = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] GAP_LV   = TW'(GAP_CYC - 1);
  localparam logic [TW-1:0] LD_LV    = TW'(LD_CYC - 1);

  seq_state_t      state_q, state_d;
  logic            auto_q, auto_d;
  logic            tmr_load;
  logic [TW-1:0]   tmr_val;
  logic            tmr_last;
  logic            accept;
  logic            wr_accept;
  logic [SMP_W-1:0] offs_code;

  assign accept    = cmd_valid && (state_q == ST_IDLE);
  assign wr_accept = accept && !cmd_update;

  dacseq_code_conv #(.W(SMP_W)) u_conv (
    .twos_in  (cmd_sample),
    .offs_out (offs_code)
  );

  dacseq_bus_regs #(.AW(CH_W), .DW(SMP_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (wr_accept),
    .addr_in (cmd_chan),
    .data_in (offs_code),
    .addr_q  (bus_addr),
    .data_q  (bus_data)
  );

  dacseq_phase_timer #(.TW(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    auto_d   = auto_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          tmr_load = 1'b1;
          if (cmd_update) begin
            state_d = ST_GAP;
            tmr_val = GAP_LV;
          end else begin
            state_d = ST_SETUP;
            tmr_val = SETUP_LV;
            auto_d  = auto_load;
          end
        end
      end
      ST_SETUP: begin
        if (tmr_last) begin
          state_d  = ST_STROBE;
          tmr_load = 1'b1;
          tmr_val  = PULSE_LV;
        end
      end
      ST_STROBE: begin
        if (tmr_last) begin
          tmr_load = 1'b1;
          if (auto_q) begin
            state_d = ST_GAP;
            tmr_val = GAP_LV;
          end else begin
            state_d = ST_HOLD;
            tmr_val = HOLD_LV;
          end
        end
      end
      ST_HOLD: begin
        if (tmr_last) state_d = ST_IDLE;
      end
      ST_GAP: begin
        if (tmr_last) begin
          state_d  = ST_LOAD;
          tmr_load = 1'b1;
          tmr_val  = LD_LV;
        end
      end
      ST_LOAD: begin
        if (tmr_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      auto_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      auto_q  <= auto_d;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign bus_cs_n  = (state_q != ST_STROBE);
  assign bus_wr_n  = (state_q != ST_STROBE);
  assign bus_ld_n  = (state_q != ST_LOAD);

endmodule

// File: rtl/dacseq_chk.sv
module dacseq_chk
  import dacseq_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int CH_W          = 3,
  parameter int SMP_W         = 14,
  parameter int STROBE_NS     = 50,
  parameter int DATA_SETUP_NS = 50,
  parameter int LOAD_GAP_NS   = 50,
  parameter int LOAD_NS       = 50
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_update,
  input logic [CH_W-1:0]  cmd_chan,
  input logic [SMP_W-1:0] cmd_sample,
  input logic             busy,
  input logic             bus_cs_n,
  input logic             bus_wr_n,
  input logic [CH_W-1:0]  bus_addr,
  input logic [SMP_W-1:0] bus_data,
  input logic             bus_ld_n
);
  localparam int PULSE_C = max2(ns_to_cyc(STROBE_NS, CLK_PERIOD_NS),
                                ns_to_cyc(DATA_SETUP_NS, CLK_PERIOD_NS));
  localparam int GAP_C   = ns_to_cyc(LOAD_GAP_NS, CLK_PERIOD_NS);
  localparam int LD_C    = ns_to_cyc(LOAD_NS, CLK_PERIOD_NS);
  localparam int CW      = 16;
  localparam logic [SMP_W-1:0] HALF = SMP_W'(1) << (SMP_W - 1);

  logic [CW-1:0] cs_low_cnt, ld_low_cnt, cs_high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_low_cnt  <= '0;
      ld_low_cnt  <= '0;
      cs_high_cnt <= CW'(GAP_C);
    end else begin
      cs_low_cnt  <= bus_cs_n ? '0 : cs_low_cnt + 1'b1;
      ld_low_cnt  <= bus_ld_n ? '0 : ld_low_cnt + 1'b1;
      if (!bus_cs_n)                  cs_high_cnt <= '0;
      else if (cs_high_cnt < CW'(GAP_C)) cs_high_cnt <= cs_high_cnt + 1'b1;
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> (bus_cs_n && bus_ld_n && cmd_ready));

  // R2
  offset_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_update) |=>
      (bus_data == ($past(cmd_sample) ^ HALF)) && (bus_addr == $past(cmd_chan)));

  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> (cs_low_cnt == CW'(PULSE_C)));

  // R5
  bus_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n || $rose(bus_wr_n)) |-> ($stable(bus_addr) && $stable(bus_data)));

  // R6
  load_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ld_n) |-> (cs_high_cnt >= CW'(GAP_C)));

  // R6
  load_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ld_n) |-> (ld_low_cnt == CW'(LD_C)));

  // R9
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (bus_cs_n && bus_wr_n && bus_ld_n && !busy));

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_ld_n && !bus_wr_n));

endmodule

bind dac_bus_sequencer dacseq_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .CH_W          (CH_W),
  .SMP_W         (SMP_W),
  .STROBE_NS     (STROBE_NS),
  .DATA_SETUP_NS (DATA_SETUP_NS),
  .LOAD_GAP_NS   (LOAD_GAP_NS),
  .LOAD_NS       (LOAD_NS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_update (cmd_update),
  .cmd_chan   (cmd_chan),
  .cmd_sample (cmd_sample),
  .busy       (busy),
  .bus_cs_n   (bus_cs_n),
  .bus_wr_n   (bus_wr_n),
  .bus_addr   (bus_addr),
  .bus_data   (bus_data),
  .bus_ld_n   (bus_ld_n)
);

// File: tb/sim_dac_bus_sequencer.sv
`timescale 1ns/1ps
module sim_dac_bus_sequencer;
  localparam int PER = 20;
  // cycle counts from the requirements: ceil(ns / period), at least 1
  localparam int SETUP_N = 1;
  localparam int PULSE_N = 3;
  localparam int HOLD_N  = 1;
  localparam int GAP_N   = 3;
  localparam int LOAD_N  = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        auto_load, cmd_valid, cmd_update;
  logic [2:0]  cmd_chan;
  logic [13:0] cmd_sample;
  logic        cmd_ready, busy, bus_cs_n, bus_wr_n, bus_ld_n;
  logic [2:0]  bus_addr;
  logic [13:0] bus_data;

  always #(PER/2) clk = ~clk;

  dac_bus_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .auto_load(auto_load), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_update(cmd_update), .cmd_chan(cmd_chan),
    .cmd_sample(cmd_sample), .busy(busy), .bus_cs_n(bus_cs_n),
    .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_ld_n(bus_ld_n)
  );

  int vec_cnt = 0;
  int err_cnt = 0;
  int ld_falls = 0;
  bit finished = 0;

  // expected vector bits: {cs_n, wr_n, ld_n, ready}
  localparam logic [3:0] V_IDLE  = 4'b1111;
  localparam logic [3:0] V_QUIET = 4'b1110;
  localparam logic [3:0] V_STRB  = 4'b0010;
  localparam logic [3:0] V_LOAD  = 4'b1100;
  logic [3:0]  exp_q[$];
  logic [3:0]  exp_now;
  logic [2:0]  exp_addr;
  logic [13:0] exp_data;

  task automatic push_n(input logic [3:0] v, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(v);
  endtask

  // behavioural reference, advanced at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q.delete();
      exp_now  = V_IDLE;
      exp_addr = '0;
      exp_data = '0;
    end else begin
      if (cmd_valid && exp_now[0]) begin
        if (!cmd_update) begin
          exp_addr = cmd_chan;
          exp_data = 14'(cmd_sample + 14'd8192);
          push_n(V_QUIET, SETUP_N);
          push_n(V_STRB, PULSE_N);
          if (auto_load) begin
            push_n(V_QUIET, GAP_N);
            push_n(V_LOAD, LOAD_N);
          end else begin
            push_n(V_QUIET, HOLD_N);
          end
        end else begin
          push_n(V_QUIET, GAP_N);
          push_n(V_LOAD, LOAD_N);
        end
      end
      if (exp_q.size() > 0) exp_now = exp_q.pop_front();
      else                  exp_now = V_IDLE;
    end
  end

  // comparison on every falling edge
  logic ld_prev = 1'b1;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      vec_cnt++;
      if ({bus_cs_n, bus_wr_n} != {exp_now[3], exp_now[2]}) begin
        err_cnt++;
        $display("FAIL R3 R4 strobe act=%b%b exp=%b%b", bus_cs_n, bus_wr_n, exp_now[3], exp_now[2]);
      end
      if (bus_ld_n != exp_now[1]) begin
        err_cnt++;
        $display("FAIL R6 R8 load act=%b exp=%b", bus_ld_n, exp_now[1]);
      end
      if (cmd_ready != exp_now[0] || busy != !exp_now[0]) begin
        err_cnt++;
        $display("FAIL R9 ready/busy act=%b/%b exp=%b/%b", cmd_ready, busy, exp_now[0], !exp_now[0]);
      end
      if (bus_addr != exp_addr || bus_data != exp_data) begin
        err_cnt++;
        $display("FAIL R2 R5 addr/data act=%0d/%h exp=%0d/%h", bus_addr, bus_data, exp_addr, exp_data);
      end
      if (!bus_ld_n && !bus_wr_n) begin
        err_cnt++;
        $display("FAIL R10 overlap act=ld_n0,wr_n0 exp=not both low");
      end
      if (ld_prev && !bus_ld_n) ld_falls++;
      ld_prev = bus_ld_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    vec_cnt++;
    if (!ok) begin
      err_cnt++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  task automatic send(input logic upd, input logic [2:0] ch, input logic [13:0] smp);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_update = upd; cmd_chan = ch; cmd_sample = smp;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      err_cnt++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end

  initial begin
    int f0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_update = 1'b0; auto_load = 1'b0;
    cmd_chan = '0; cmd_sample = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_cs_n && bus_wr_n && bus_ld_n, "R1 strobes high", {bus_cs_n, bus_wr_n, bus_ld_n}, 7);
    chk(cmd_ready && !busy, "R1 ready", cmd_ready, 1);
    chk(bus_data == 0 && bus_addr == 0, "R1 bus zero", bus_data, 0);
    rst_n = 1'b1;

    // R2 R6: auto-load writes, extreme codes
    auto_load = 1'b1;
    send(1'b0, 3'd5, 14'h3FFF);
    wait_idle();
    chk(bus_data == 14'h1FFF, "R2 minus one", bus_data, 14'h1FFF);
    chk(bus_addr == 3'd5, "R2 channel", bus_addr, 5);
    chk(ld_falls == 1, "R6 one load", ld_falls, 1);
    send(1'b0, 3'd0, 14'h2000);
    wait_idle();
    chk(bus_data == 14'h0000, "R2 most negative", bus_data, 0);
    chk(ld_falls == 2, "R6 second load", ld_falls, 2);

    // R7: no load without auto-load
    auto_load = 1'b0;
    send(1'b0, 3'd7, 14'h1FFF);
    wait_idle();
    chk(bus_data == 14'h3FFF, "R2 most positive", bus_data, 14'h3FFF);
    chk(ld_falls == 2, "R7 no load", ld_falls, 2);

    // R8: batched writes then one update
    send(1'b0, 3'd1, 14'd100);
    send(1'b0, 3'd2, 14'h3F9C);
    send(1'b0, 3'd3, 14'd0);
    wait_idle();
    chk(ld_falls == 2, "R7 batch no load", ld_falls, 2);
    send(1'b1, 3'd6, 14'h1234);
    wait_idle();
    chk(ld_falls == 3, "R8 update load", ld_falls, 3);
    chk(bus_data == 14'h2000 && bus_addr == 3'd3, "R8 data kept", bus_data, 14'h2000);

    // R9: command offered while busy is not taken
    send(1'b0, 3'd4, 14'd123);
    cmd_valid = 1'b1; cmd_update = 1'b0; cmd_chan = 3'd6; cmd_sample = 14'd55;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b0;
    wait_idle();
    chk(bus_addr == 3'd4, "R9 channel kept", bus_addr, 4);
    chk(bus_data == 14'd8315, "R9 data kept", bus_data, 8315);

    // R11: auto-load captured at acceptance
    f0 = ld_falls;
    auto_load = 1'b1;
    send(1'b0, 3'd2, 14'd1);
    auto_load = 1'b0;
    wait_idle();
    chk(ld_falls == f0 + 1, "R11 captured on", ld_falls, f0 + 1);
    send(1'b0, 3'd3, 14'd2);
    auto_load = 1'b1;
    wait_idle();
    chk(ld_falls == f0 + 1, "R11 captured off", ld_falls, f0 + 1);

    // R8 update under auto-load gives a single pulse
    send(1'b1, 3'd0, 14'd0);
    wait_idle();
    chk(ld_falls == f0 + 2, "R8 auto update", ld_falls, f0 + 2);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  end
endmodule